// File: doc/BRIEF.md
# Stored-Frame Byte Streamer

This block holds one prebuilt Ethernet frame in a dual-port memory. It sends that frame, one byte per accepted beat, to a raw byte-wide MAC or PHY client interface. A host fills the memory through a write port and sets a frame length register. A single-cycle start pulse then sends exactly one copy of the frame. The transmit side walks the memory from address zero up to the programmed length. It stops at the final byte and does not return to address zero, so a second copy of the frame needs a second start pulse.

Each byte is offered with a valid flag. The first byte also carries a start flag and the last byte carries an end flag. The byte is held until the downstream side acknowledges it. While the acknowledge stays high, one byte moves on every clock. The host keeps its own memory port at all times. It can rewrite any byte, for example the destination address, while the block is idle or while a frame is going out. A byte that has not yet been fetched is sent with its new value.

Top module: `pkt_tx_top`

## Requirements
- R1: While reset is active, and in the first cycle after it, `tx_valid_o`, `tx_sop_o`, `tx_eop_o` and `busy_o` are 0. The frame length register comes out of reset holding 14.
- R2: When `go_i` is high in a cycle where `busy_o` is low, the next cycle shows `tx_valid_o`=1, `tx_sop_o`=1 and `busy_o`=1, with the byte stored at address 0 on `tx_data_o`.
- R3: The k-th handshake (a cycle with `tx_valid_o`=1 and `tx_ack_i`=1, counting from 0) transfers the byte stored at address k. While `tx_valid_o`=1 and `tx_ack_i`=0, the next cycle keeps `tx_valid_o`=1 and keeps `tx_data_o` unchanged.
- R4: If `tx_ack_i` stays high, a frame of L bytes occupies exactly L consecutive valid cycles, with no gaps.
- R5: `tx_eop_o` is high only with the byte at address L-1. After that byte's handshake, `tx_valid_o` goes to 0 on the next cycle and stays 0 until the next accepted `go_i`. A frame is never longer than L bytes.
- R6: A `go_i` pulse while `busy_o` is high is ignored. The current frame keeps its length and content, and no second frame follows it.
- R7: A write through `len_we_i` is accepted only when `len_i` is between 14 and DEPTH (2048), inclusive. Any other value leaves the register unchanged. The length is captured when a frame starts, so a write made during a frame applies from the next frame.
- R8: A host write (`hst_we_i`) stores `hst_wdata_i` at `hst_addr_i`. `hst_rdata_o` returns the byte at `hst_addr_i` one cycle later. A write made while the block is idle appears in the next frame. A write made during a frame, to an address that has not yet been fetched, appears in that same frame.
- R9: `tx_sop_o` is high only with the first byte of a frame. `tx_sop_o` and `tx_eop_o` are never high while `tx_valid_o` is low.
- R10: `busy_o` is high in every cycle in which `tx_valid_o` is high, and it is low once the frame has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Start pulse for one frame |
| busy_o | output | 1 | High while a frame is being sent |
| len_we_i | input | 1 | Write strobe for the frame length register |
| len_i | input | LW (12) | New frame length in bytes |
| hst_we_i | input | 1 | Host memory write strobe |
| hst_addr_i | input | AW (11) | Host memory address, used for both write and read |
| hst_wdata_i | input | DW (8) | Host write byte |
| hst_rdata_o | output | DW (8) | Host read byte, one cycle after the address |
| tx_data_o | output | DW (8) | Outgoing byte |
| tx_valid_o | output | 1 | Outgoing byte is valid |
| tx_sop_o | output | 1 | First byte of the frame |
| tx_eop_o | output | 1 | Last byte of the frame |
| tx_ack_i | input | 1 | Downstream accepts the byte in this cycle |

## Verification
An address counter that is off by one shows up at the very next handshake as a wrong byte, or as the start or end flag appearing on the wrong beat. If the counter wraps, `tx_valid_o` rises again one cycle after the end byte. A length register that is latched wrongly, or that accepts an illegal value, shows up as a wrong byte count by the end of the frame. A read that is issued on a stalled beat changes `tx_data_o` in the cycle after the stall begins. The bench uses acknowledge patterns that are always high, that alternate, that come one in three, and that start late, so that each of these faults can surface.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } tx_state_e;
endpackage

// File: rtl/pkt_tx_ram.sv
module pkt_tx_ram #(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] hrd_data_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q, hrd_q;

  // read-first on both ports; rd_q holds while rd_en_i is low
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
    if (rd_en_i) rd_q <= mem[rd_addr_i];
    hrd_q <= mem[wr_addr_i];
  end

  assign rd_data_o  = rd_q;
  assign hrd_data_o = hrd_q;
endmodule

// File: rtl/pkt_tx_len_reg.sv
module pkt_tx_len_reg #(
  parameter int unsigned LW      = 12,
  parameter int unsigned MIN_LEN = 14,
  parameter int unsigned MAX_LEN = 2048
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [LW-1:0] val_i,
  output logic [LW-1:0] len_o
);
  logic [LW-1:0] len_q;
  logic          legal;

  assign legal = (val_i >= LW'(MIN_LEN)) && (val_i <= LW'(MAX_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             len_q <= LW'(MIN_LEN);
    else if (we_i && legal)  len_q <= val_i;
  end

  assign len_o = len_q;

  assert_bad_len_dropped_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ((val_i < LW'(MIN_LEN)) || (val_i > LW'(MAX_LEN)))) |=> $stable(len_o));
endmodule

// File: rtl/pkt_tx_seq.sv
module pkt_tx_seq
  import pkt_tx_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter int unsigned LW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          ack_i,
  input  logic [LW-1:0] frame_len_i,
  output logic          busy_o,
  output logic          valid_o,
  output logic          sop_o,
  output logic          eop_o,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o
);
  tx_state_e     state_q;
  logic [AW-1:0] idx_q, last_q;
  logic [LW-1:0] len_m1;
  logic          start, fire;

  assign len_m1  = frame_len_i - LW'(1);
  assign valid_o = (state_q == ST_SEND);
  assign busy_o  = valid_o;
  assign sop_o   = valid_o && (idx_q == '0);
  assign eop_o   = valid_o && (idx_q == last_q);
  assign start   = (state_q == ST_IDLE) && go_i;
  assign fire    = valid_o && ack_i;

  // fetch next byte as the current one is taken; nothing past the last
  assign rd_en_o   = start || (fire && !eop_o);
  assign rd_addr_o = start ? '0 : idx_q + AW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (go_i) begin
          state_q <= ST_SEND;
          idx_q   <= '0;
          last_q  <= len_m1[AW-1:0];
        end
        ST_SEND: if (fire) begin
          if (eop_o) state_q <= ST_IDLE;
          else       idx_q   <= idx_q + AW'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_go_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && !busy_o) |=> (valid_o && sop_o && busy_o));
  assert_no_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && eop_o) |=> !valid_o);
  assert_idx_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (idx_q <= last_q));
  assert_go_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && go_i && !sop_o) |=> !sop_o);
  assert_sop_once_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && sop_o && !eop_o) |=> (valid_o && !sop_o));
endmodule

// File: rtl/pkt_tx_top.sv
module pkt_tx_top #(
  parameter int unsigned DEPTH   = 2048,
  parameter int unsigned DW      = 8,
  parameter int unsigned MIN_LEN = 14,
  parameter int unsigned AW      = $clog2(DEPTH),
  parameter int unsigned LW      = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  output logic          busy_o,
  input  logic          len_we_i,
  input  logic [LW-1:0] len_i,
  input  logic          hst_we_i,
  input  logic [AW-1:0] hst_addr_i,
  input  logic [DW-1:0] hst_wdata_i,
  output logic [DW-1:0] hst_rdata_o,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_valid_o,
  output logic          tx_sop_o,
  output logic          tx_eop_o,
  input  logic          tx_ack_i
);
  logic [LW-1:0] frame_len;
  logic          rd_en;
  logic [AW-1:0] rd_addr;

  pkt_tx_len_reg #(.LW(LW), .MIN_LEN(MIN_LEN), .MAX_LEN(DEPTH)) u_len (
    .clk_i (clk_i), .rst_ni(rst_ni), .we_i(len_we_i), .val_i(len_i), .len_o(frame_len)
  );

  pkt_tx_seq #(.AW(AW), .LW(LW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (go_i),
    .ack_i      (tx_ack_i),
    .frame_len_i(frame_len),
    .busy_o     (busy_o),
    .valid_o    (tx_valid_o),
    .sop_o      (tx_sop_o),
    .eop_o      (tx_eop_o),
    .rd_en_o    (rd_en),
    .rd_addr_o  (rd_addr)
  );

  pkt_tx_ram #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_ram (
    .clk_i     (clk_i),
    .rd_en_i   (rd_en),
    .rd_addr_i (rd_addr),
    .rd_data_o (tx_data_o),
    .wr_en_i   (hst_we_i),
    .wr_addr_i (hst_addr_i),
    .wr_data_i (hst_wdata_i),
    .hrd_data_o(hst_rdata_o)
  );

  assert_stall_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ack_i) |=> (tx_valid_o && $stable(tx_data_o)));
  assert_flags_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_valid_o |-> (!tx_sop_o && !tx_eop_o));
  assert_busy_cover_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> busy_o);
endmodule

// File: tb/sim_pkt_tx_top.sv
module sim_pkt_tx_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 2048;
  localparam int AW = 11;
  localparam int LW = 12;
  localparam int NVEC = 6;
  localparam int VEC_LEN  [NVEC] = '{14, 60, 2048, 100, 33, 15};
  localparam int VEC_MODE [NVEC] = '{0, 1, 0, 2, 3, 1};
  localparam int VEC_SEED [NVEC] = '{1, 2, 3, 4, 5, 6};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0, len_we = 1'b0, hst_we = 1'b0, ack = 1'b0;
  logic [LW-1:0] len_v = '0;
  logic [AW-1:0] hst_addr = '0;
  logic [7:0] hst_wdata = '0;
  logic [7:0] hst_rdata, tx_data;
  logic busy, tx_valid, tx_sop, tx_eop;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_mem [DEPTH];
  logic [7:0] cap [DEPTH];
  int cap_cnt, eop_cnt, eop_pos, sop_bad, stall_bad, busy_bad, valid_cycles, extra;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_tx_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .go_i(go), .busy_o(busy),
    .len_we_i(len_we), .len_i(len_v),
    .hst_we_i(hst_we), .hst_addr_i(hst_addr), .hst_wdata_i(hst_wdata), .hst_rdata_o(hst_rdata),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_sop_o(tx_sop), .tx_eop_o(tx_eop),
    .tx_ack_i(ack)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  function automatic logic [7:0] pat(input int a, input int seed);
    return 8'((a * 7) + (seed * 13) + (a >> 3));
  endfunction

  task automatic host_wr(input int a, input logic [7:0] d);
    hst_we = 1'b1; hst_addr = AW'(a); hst_wdata = d;
    exp_mem[a] = d;
    tick;
    hst_we = 1'b0;
  endtask

  task automatic fill(input int len, input int seed);
    for (int a = 0; a < len; a++) host_wr(a, pat(a, seed));
  endtask

  task automatic set_len(input int v);
    len_we = 1'b1; len_v = LW'(v);
    tick;
    len_we = 1'b0;
  endtask

  // mode 0: ack always, 1: alternate, 2: one in three, 3: late first ack
  task automatic run_frame(input int mode, input int go_at, input int len_at, input int len_val,
                           input int edit_at, input int edit_addr, input logic [7:0] edit_val);
    int cyc = 0;
    bit done = 0;
    bit holding = 0;
    logic [7:0] held = '0;
    logic ackv;
    cap_cnt = 0; eop_cnt = 0; eop_pos = -1; sop_bad = 0; stall_bad = 0;
    busy_bad = 0; valid_cycles = 0; extra = 0;
    go = 1'b1; tick; go = 1'b0;
    while (!done && cyc < 20000) begin
      go = (cyc == go_at);
      len_we = (cyc == len_at); len_v = LW'(len_val);
      hst_we = 1'b0;
      if (cyc == edit_at) begin
        hst_we = 1'b1; hst_addr = AW'(edit_addr); hst_wdata = edit_val;
        exp_mem[edit_addr] = edit_val;
      end
      ackv = 1'b0;
      if (tx_valid) begin
        valid_cycles++;
        if (!busy) busy_bad++;
        if (holding && tx_data !== held) stall_bad++;
        case (mode)
          0: ackv = 1'b1;
          1: ackv = (cyc % 2) == 1;
          2: ackv = (cyc % 3) == 2;
          default: ackv = valid_cycles > 4;
        endcase
        if (tx_sop != (cap_cnt == 0)) sop_bad++;
        if (ackv) begin
          if (cap_cnt < DEPTH) cap[cap_cnt] = tx_data;
          if (tx_eop) begin eop_cnt++; eop_pos = cap_cnt; done = 1; end
          cap_cnt++;
          holding = 0;
        end else begin
          holding = 1; held = tx_data;
        end
      end else if (tx_sop || tx_eop) sop_bad++;
      ack = ackv;
      cyc++;
      tick;
    end
    go = 1'b0; len_we = 1'b0; hst_we = 1'b0; ack = 1'b1;
    for (int i = 0; i < 12; i++) begin
      if (tx_valid || busy) extra++;
      tick;
    end
    ack = 1'b0;
  endtask

  task automatic verify(input int len, input int mode);
    int mism = 0;
    for (int i = 0; i < len && i < cap_cnt; i++) if (cap[i] !== exp_mem[i]) mism++;
    chk(cap_cnt == len, "R5 byte count", cap_cnt, len);
    chk(mism == 0, "R3 byte order/content mismatches", mism, 0);
    chk(eop_cnt == 1 && eop_pos == len - 1, "R5 eop position", eop_pos, len - 1);
    chk(sop_bad == 0, "R9 sop/flag placement errors", sop_bad, 0);
    chk(stall_bad == 0, "R3 data change under stall", stall_bad, 0);
    chk(busy_bad == 0, "R10 valid without busy", busy_bad, 0);
    chk(extra == 0, "R5 no wrap / R6 no second frame", extra, 0);
    if (mode == 0) chk(valid_cycles == len, "R4 back-to-back cycles", valid_cycles, len);
  endtask

  initial begin
    #(CLK_PERIOD * 180000);
    chk(0, "R4 watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) tick;
    // R1 during reset
    chk(!tx_valid && !busy && !tx_sop && !tx_eop, "R1 outputs in reset", {tx_valid, busy, tx_sop, tx_eop}, 0);
    rst_n = 1'b1;
    tick;
    chk(!tx_valid && !busy, "R1 outputs after reset", {tx_valid, busy}, 0);
    // R1 default length 14, R2 start
    fill(14, 9);
    go = 1'b1; tick; go = 1'b0;
    chk(tx_valid && tx_sop && busy && tx_data == exp_mem[0], "R2 first beat after go",
        {tx_valid, tx_sop, busy}, 7);
    ack = 1'b1;
    repeat (14) tick;
    ack = 1'b0;
    chk(!tx_valid && !busy, "R5 idle after default frame", {tx_valid, busy}, 0);
    run_frame(0, -1, -1, 0, -1, 0, 8'h00);
    verify(14, 0);
    chk(cap_cnt == 14, "R1 reset length 14", cap_cnt, 14);

    // table of vectors
    for (int v = 0; v < NVEC; v++) begin
      set_len(VEC_LEN[v]);
      fill(VEC_LEN[v], VEC_SEED[v]);
      run_frame(VEC_MODE[v], -1, -1, 0, -1, 0, 8'h00);
      verify(VEC_LEN[v], VEC_MODE[v]);
    end

    // R6 go while busy
    set_len(40); fill(40, 11);
    run_frame(1, 5, -1, 0, -1, 0, 8'h00);
    verify(40, 1);

    // R7 illegal lengths ignored
    set_len(50); fill(50, 12);
    set_len(13); set_len(2049); set_len(0);
    run_frame(0, -1, -1, 0, -1, 0, 8'h00);
    verify(50, 0);
    chk(cap_cnt == 50, "R7 illegal lengths dropped", cap_cnt, 50);

    // R7 mid-frame length write applies next frame
    set_len(30); fill(30, 13);
    run_frame(2, -1, 3, 20, -1, 0, 8'h00);
    verify(30, 2);
    run_frame(0, -1, -1, 0, -1, 0, 8'h00);
    verify(20, 0);
    chk(cap_cnt == 20, "R7 new length on next frame", cap_cnt, 20);

    // R8 idle edit with readback
    host_wr(6, 8'h5C);
    hst_addr = AW'(6); tick;
    rd = hst_rdata;
    chk(rd == 8'h5C, "R8 host readback", rd, 8'h5C);
    run_frame(0, -1, -1, 0, -1, 0, 8'h00);
    verify(20, 0);
    chk(cap[6] == 8'h5C, "R8 idle edit in next frame", cap[6], 8'h5C);

    // R8 edit during frame ahead of the read pointer
    set_len(80); fill(80, 14);
    run_frame(1, -1, -1, 0, 3, 70, 8'hA5);
    verify(80, 1);
    chk(cap[70] == 8'hA5, "R8 live edit in current frame", cap[70], 8'hA5);

    // R1 reset mid-frame
    go = 1'b1; tick; go = 1'b0;
    tick;
    rst_n = 1'b0; #1;
    chk(!tx_valid && !busy, "R1 reset aborts frame", {tx_valid, busy}, 0);
    tick; rst_n = 1'b1; tick;
    chk(!tx_valid && !busy, "R1 idle after reset release", {tx_valid, busy}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule